// File: doc/BRIEF.md
# Local-to-Global Event Converter

This block watches a bank of single-bit local event pins, all synchronous to the block clock, and turns their activity into counted global event messages. Each pin is configured on its own: it can be enabled or disabled, it can count every cycle in which it is high (pulse mode) or only its low-to-high transitions (edge mode), and it carries a programmable global event index that is stamped on the messages it produces.

Each pin has its own pending-occurrence accumulator. A round-robin arbiter picks one enabled pin with a non-zero accumulator whenever the egress holding register is free or is being emptied. The pin's whole accumulated amount moves into that register as the message count. Occurrences that land in the same cycle as the drain stay behind as residue. The egress port is a valid/ready interface whose messages always carry the "up" flag. Routing and counting downstream are left to the fabric beyond this port.

Top module: `lge_converter`

## Requirements
- R1: After reset every pin is disabled and `eg_valid` is 0. Pin activity before any configuration write produces no message.
- R2: A pin whose mode bit (`cfg_edge`) was written as 0 (pulse mode) counts one occurrence for every clock cycle in which it is sampled high.
- R3: A pin whose mode bit was written as 1 (edge mode) counts one occurrence per low-to-high transition, judged against the pin's value in the previous cycle. A pin held high counts once.
- R4: Every message produced for a pin carries, on `eg_index`, the 10-bit index last written for that pin.
- R5: While `eg_valid` is 1 and `eg_ready` is 0, `eg_valid`, `eg_index` and `eg_cnt` hold their values.
- R6: A message moves the whole accumulated amount of the chosen pin into `eg_cnt`, which is never 0. Occurrences in the drain cycle stay in the accumulator, so the sum of the counts delivered for a pin equals its occurrences.
- R7: When several pins are pending, the pins are served in round-robin order. The search starts at the pin after the last one served, wrapping from pin 7 to pin 0, and starts at pin 0 after reset.
- R8: A pin's accumulator saturates at 65535 (the largest 16-bit count) and never wraps.
- R9: A disabled pin neither counts nor emits, and its pending accumulator is dropped. A message already in the egress register is still delivered. In edge mode, enabling a pin while it is high counts no edge.
- R10: `eg_up` is 1 whenever `eg_valid` is 1.
- R11: With an empty egress register and no other pending pin, a one-cycle pulse sampled at clock edge t raises `eg_valid` after edge t+1 with `eg_cnt` = 1. Once accepted, the message leaves at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Local event pins, bit n is pin n |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_pin | input | 3 | Pin number addressed by the write |
| cfg_enable | input | 1 | Enable bit for the addressed pin |
| cfg_edge | input | 1 | Mode: 0 pulse, 1 rising edge |
| cfg_index | input | 10 | Global event index for the addressed pin |
| eg_valid | output | 1 | Egress message present |
| eg_ready | input | 1 | Downstream accepts the message this cycle |
| eg_up | output | 1 | Up flag of the message, always set |
| eg_index | output | 10 | Global event index of the message |
| eg_cnt | output | 16 | Occurrence count carried by the message |

## Verification
The assertions assume that `cfg_pin` names an existing pin during a write, and that the pins and `eg_ready` only change away from the active clock edge. The stability check on a stalled message also assumes that the consumer never withdraws a message once it is offered. The bench drives every input on the falling edge and raises configuration strobes for exactly one cycle. It addresses only pins 0 to 7 and keeps `eg_ready` constant through each stall window, so the stimulus stays within those assumptions.

// File: rtl/lge_pkg.sv
package lge_pkg;

  typedef enum logic {
    MODE_PULSE = 1'b0,
    MODE_EDGE  = 1'b1
  } lge_mode_e;

  // One occurrence for this cycle, given mode, enable, pin and the pin's previous value
  function automatic logic occ_hit(input lge_mode_e mode, input logic en,
                                   input logic pin, input logic prev);
    logic hit;
    if (mode == MODE_EDGE) hit = pin & ~prev;
    else                   hit = pin;
    return en & hit;
  endfunction

endpackage

// File: rtl/lge_detect.sv
module lge_detect
  import lge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  lge_mode_e mode,
  input  logic      pin,
  output logic      occ
);

  logic prev_q;

  // The previous-value register tracks the pin even when disabled, so that
  // enabling a pin that is already high sees no rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin;
  end

  assign occ = occ_hit(mode, en, pin, prev_q);

  AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (occ && mode == MODE_EDGE) |=> !(occ && mode == MODE_EDGE)); // R3

endmodule

// File: rtl/lge_accum.sv
module lge_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             occ,
  input  logic             drain,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pending
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] a, input logic inc);
    if (inc && (a != CNT_MAX)) return a + 1'b1;
    return a;
  endfunction

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    base = drain ? '0 : cnt_q;
    if (!en) cnt_d = '0;
    else     cnt_d = sat_inc(base, occ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pending = en && (cnt_q != '0);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !drain && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R8
  AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R9
  AST_RESIDUE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && drain && occ) |=> (cnt_q == 1)); // R6

endmodule

// File: rtl/lge_rr_arb.sv
module lge_rr_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q;

  // First requester at or after the pointer, wrapping around
  function automatic logic [IW-1:0] rr_pick(input logic [N-1:0] r, input logic [IW-1:0] p);
    logic [IW-1:0] pick;
    logic          found;
    pick  = '0;
    found = 1'b0;
    for (int off = 0; off < N; off++) begin
      int k;
      k = (int'(p) + off) % N;
      if (!found && r[k]) begin
        pick  = IW'(k);
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  always_comb begin
    gnt_idx = rr_pick(req, ptr_q);
    gnt     = '0;
    if (|req) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (advance && |req) ptr_q <= (gnt_idx == LAST) ? '0 : gnt_idx + 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R7
  AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R7
  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt)); // R7

endmodule

// File: rtl/lge_converter.sv
module lge_converter
  import lge_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CNT_W    = 16,
  parameter int IDX_W    = 10,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                cfg_we,
  input  logic [PIN_W-1:0]    cfg_pin,
  input  logic                cfg_enable,
  input  logic                cfg_edge,
  input  logic [IDX_W-1:0]    cfg_index,
  output logic                eg_valid,
  input  logic                eg_ready,
  output logic                eg_up,
  output logic [IDX_W-1:0]    eg_index,
  output logic [CNT_W-1:0]    eg_cnt
);

  // Per-pin configuration
  logic      [NUM_PINS-1:0] en_q;
  lge_mode_e                mode_q [NUM_PINS];
  logic [IDX_W-1:0]         map_q  [NUM_PINS];

  // Named internal events for the checks
  logic [NUM_PINS-1:0] occ;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] gnt;
  logic [NUM_PINS-1:0] drain;
  logic [PIN_W-1:0]    gnt_idx;
  logic [CNT_W-1:0]    acc [NUM_PINS];
  logic                load;
  logic                take;

  logic             out_valid_q;
  logic [IDX_W-1:0] out_idx_q;
  logic [CNT_W-1:0] out_cnt_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g]   <= 1'b0;
        mode_q[g] <= MODE_PULSE;
        map_q[g]  <= '0;
      end else if (cfg_we && cfg_pin == PIN_W'(g)) begin
        en_q[g]   <= cfg_enable;
        mode_q[g] <= lge_mode_e'(cfg_edge);
        map_q[g]  <= cfg_index;
      end
    end

    lge_detect u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q[g]),
      .mode  (mode_q[g]),
      .pin   (pin_i[g]),
      .occ   (occ[g])
    );

    lge_accum #(.CNT_W(CNT_W)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q[g]),
      .occ     (occ[g]),
      .drain   (drain[g]),
      .cnt_q   (acc[g]),
      .pending (pend[g])
    );

    assign drain[g] = load & gnt[g];
  end

  lge_rr_arb #(.N(NUM_PINS)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (pend),
    .advance (load),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
  );

  assign take = out_valid_q & eg_ready;
  assign load = (|pend) & (!out_valid_q | eg_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_idx_q   <= '0;
      out_cnt_q   <= '0;
    end else if (load) begin
      out_valid_q <= 1'b1;
      out_idx_q   <= map_q[gnt_idx];
      out_cnt_q   <= acc[gnt_idx];
    end else if (take) begin
      out_valid_q <= 1'b0;
    end
  end

  assign eg_valid = out_valid_q;
  assign eg_up    = 1'b1;
  assign eg_index = out_idx_q;
  assign eg_cnt   = out_cnt_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eg_valid && !eg_ready) |=> (eg_valid && $stable(eg_index) && $stable(eg_cnt))); // R5
  AST_NONZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    eg_valid |-> (eg_cnt != '0)); // R6
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && !$past(load)) |-> (load == 1'b0)); // R1

endmodule

// File: tb/lge_converter_bench.sv
module lge_converter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_i = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_pin = '0;
  logic        cfg_enable = 1'b0;
  logic        cfg_edge = 1'b0;
  logic [9:0]  cfg_index = '0;
  logic        eg_valid;
  logic        eg_ready = 1'b0;
  logic        eg_up;
  logic [9:0]  eg_index;
  logic [15:0] eg_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [9:0]  log_idx [16];
  logic [15:0] log_cnt [16];
  int          n_log;

  always #5 clk = ~clk;

  lge_converter u_lge_converter (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_enable(cfg_enable),
    .cfg_edge(cfg_edge), .cfg_index(cfg_index),
    .eg_valid(eg_valid), .eg_ready(eg_ready), .eg_up(eg_up),
    .eg_index(eg_index), .eg_cnt(eg_cnt)
  );

  // {pin, edge, index, pattern (bit k = cycle k), expected count}
  localparam logic [29:0] VECS [6] = '{
    {3'd0, 1'b0, 10'h005, 12'b0000_0000_0111, 4'd3},
    {3'd1, 1'b1, 10'h3FF, 12'b0000_0000_0111, 4'd1},
    {3'd2, 1'b1, 10'h123, 12'b1010_1010_1010, 4'd6},
    {3'd3, 1'b0, 10'h200, 12'b1111_1111_1111, 4'd12},
    {3'd7, 1'b1, 10'h001, 12'b0110_0110_0110, 4'd3},
    {3'd5, 1'b0, 10'h0AA, 12'b1001_0000_0001, 4'd3}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pin_i = '0;
    eg_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int p, input bit en, input bit edge_m, input logic [9:0] idx);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin = 3'(p); cfg_enable = en; cfg_edge = edge_m; cfg_index = idx;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Holds ready high for a number of cycles and logs every accepted message
  task automatic collect(input int cycles);
    n_log = 0;
    @(negedge clk);
    eg_ready = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      if (eg_valid) begin
        chk(eg_up == 1'b1, "R10", "up flag", eg_up, 1);
        if (n_log < 16) begin
          log_idx[n_log] = eg_index;
          log_cnt[n_log] = eg_cnt;
        end
        n_log++;
      end
      @(negedge clk);
    end
    eg_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int total;
    do_reset();

    // R1: idle after reset, unconfigured pins are silent
    chk(eg_valid == 1'b0, "R1", "valid after reset", eg_valid, 0);
    pin_i = 8'hFF;
    eg_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(eg_valid == 1'b0, "R1", "valid with unconfigured pins", eg_valid, 0);
    pin_i = '0;
    eg_ready = 1'b0;
    repeat (2) @(negedge clk);

    // Vector table: R2 pulse, R3 edge, R4 index, R6 full transfer of counts
    foreach (VECS[v]) begin
      int          p;
      bit          em;
      logic [9:0]  ix;
      logic [11:0] pat;
      int          ex;
      bit          idx_ok;
      {p, em, ix, pat, ex} = {29'(VECS[v][29:27]), VECS[v][26], VECS[v][25:16], VECS[v][15:4], 32'(VECS[v][3:0])};
      p  = int'(VECS[v][29:27]);
      em = VECS[v][26];
      ix = VECS[v][25:16];
      pat = VECS[v][15:4];
      ex = int'(VECS[v][3:0]);
      cfg(p, 1'b1, em, ix);
      for (int k = 0; k < 12; k++) begin
        pin_i[p] = pat[k];
        @(negedge clk);
      end
      pin_i[p] = 1'b0;
      collect(20);
      total = 0;
      idx_ok = 1'b1;
      for (int m = 0; m < n_log && m < 16; m++) begin
        total += int'(log_cnt[m]);
        if (log_idx[m] != ix) idx_ok = 1'b0;
      end
      if (em) chk(total == ex, "R3", "edge-mode total", total, ex);
      else    chk(total == ex, "R2", "pulse-mode total", total, ex);
      chk(idx_ok, "R4", "message index", log_idx[0], ix);
      chk(n_log >= 1, "R6", "messages delivered", n_log, 1);
      cfg(p, 1'b0, em, ix);
    end

    // R11: latency of a single pulse
    cfg(4, 1'b1, 1'b0, 10'h044);
    eg_ready = 1'b1;
    pin_i[4] = 1'b1;
    @(negedge clk);
    pin_i[4] = 1'b0;
    chk(eg_valid == 1'b0, "R11", "valid one edge after pulse", eg_valid, 0);
    @(negedge clk);
    chk(eg_valid == 1'b1 && eg_cnt == 16'd1, "R11", "valid two edges after pulse", eg_cnt, 1);
    chk(eg_index == 10'h044, "R4", "latency message index", eg_index, 10'h044);
    @(negedge clk);
    chk(eg_valid == 1'b0, "R11", "valid after acceptance", eg_valid, 0);
    eg_ready = 1'b0;
    cfg(4, 1'b0, 1'b0, 10'h044);

    // R9: enabling an edge pin while high counts nothing
    pin_i[6] = 1'b1;
    repeat (2) @(negedge clk);
    cfg(6, 1'b1, 1'b1, 10'h066);
    collect(6);
    chk(n_log == 0, "R9", "edge pin enabled while high", n_log, 0);
    pin_i[6] = 1'b0;
    @(negedge clk);
    pin_i[6] = 1'b1;
    @(negedge clk);
    pin_i[6] = 1'b0;
    collect(6);
    chk(n_log == 1 && log_cnt[0] == 16'd1, "R9", "edge after enable", log_cnt[0], 1);
    cfg(6, 1'b0, 1'b1, 10'h066);

    // R9: disabling drops pending, keeps the held message
    cfg(5, 1'b1, 1'b0, 10'h055);
    pin_i[5] = 1'b1;
    repeat (3) @(negedge clk);
    pin_i[5] = 1'b0;
    cfg(5, 1'b0, 1'b0, 10'h055);
    collect(8);
    total = 0;
    for (int m = 0; m < n_log && m < 16; m++) total += int'(log_cnt[m]);
    chk(total == 1, "R9", "total after disable", total, 1);

    // R7: round-robin order
    do_reset();
    cfg(0, 1'b1, 1'b0, 10'h010);
    cfg(1, 1'b1, 1'b0, 10'h011);
    cfg(2, 1'b1, 1'b0, 10'h012);
    pin_i[2:0] = 3'b111;
    @(negedge clk);
    pin_i[2:0] = 3'b000;
    repeat (3) @(negedge clk);
    collect(8);
    chk(n_log == 3 && log_idx[0] == 10'h010 && log_idx[1] == 10'h011 && log_idx[2] == 10'h012,
        "R7", "first round order", log_idx[0], 10'h010);
    pin_i[1] = 1'b1;
    @(negedge clk);
    pin_i[1] = 1'b0;
    collect(6);
    chk(n_log == 1 && log_idx[0] == 10'h011, "R7", "single pin round", log_idx[0], 10'h011);
    pin_i[2:0] = 3'b111;
    @(negedge clk);
    pin_i[2:0] = 3'b000;
    repeat (3) @(negedge clk);
    collect(8);
    chk(n_log == 3 && log_idx[0] == 10'h012, "R7", "rotated first grant", log_idx[0], 10'h012);
    chk(log_idx[1] == 10'h010 && log_idx[2] == 10'h011, "R7", "rotated second grant", log_idx[1], 10'h010);

    // R8 and R5: saturation under a long stall
    do_reset();
    cfg(1, 1'b1, 1'b0, 10'h101);
    pin_i[1] = 1'b1;
    repeat (66000) @(negedge clk);
    pin_i[1] = 1'b0;
    begin
      logic [15:0] c0;
      logic [9:0]  i0;
      c0 = eg_cnt;
      i0 = eg_index;
      repeat (3) @(negedge clk);
      chk(eg_valid == 1'b1 && eg_cnt == c0 && eg_index == i0, "R5", "stalled message stable", eg_cnt, c0);
    end
    collect(6);
    chk(n_log == 2, "R8", "message count after saturation", n_log, 2);
    chk(log_cnt[1] == 16'hFFFF, "R8", "saturated count", log_cnt[1], 65535);
    chk(log_cnt[0] == 16'd1, "R6", "first drained amount", log_cnt[0], 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule